// File: doc/BRIEF.md
# Latched Interrupt Priority Arbiter

This block sits between a set of peripheral interrupt request lines and a CPU core. Each source has its own enable bit. A global mask bit is held inside the block. The block looks at the pending requests only when the CPU reports that an instruction has finished. It never breaks into an instruction that is still running.

At such a boundary, the mask may be clear and at least one enabled source may be requesting. In that case the block picks the lowest-numbered of those sources. It stores that source number as a fixed index that the CPU uses to choose a vector. It then raises a one-cycle take strobe and sets the mask. Otherwise it raises a one-cycle fetch-next strobe, so the CPU carries on with its next instruction.

Once a winner is stored, no later request can replace it, whatever its priority. The stored winner stays until the CPU acknowledges service at vector fetch or clears the mask.

Top module: `irq_arbiter_top`

## Requirements
- R1: Requests are evaluated only in a cycle where `insn_done_i` is high. Without it, `take_o` stays low whatever the requests.
- R2: A boundary leads to a take only if the mask is clear and at least one source has both its request bit and its enable bit set. A pending request with its enable bit clear has no effect.
- R3: Priority is fixed. Bit 0 of `req_i`/`en_i` is the highest-priority source and bit NUM_SRC-1 the lowest. `src_idx_o` gives the winner's bit number in binary.
- R4: After a taking boundary, `take_o` is high for exactly the cycle after that edge. From the same edge `src_vld_o` is high and `src_idx_o` holds the winner, unchanged, until the latch is released.
- R5: While `src_vld_o` is high, further boundaries do not take and do not change `src_idx_o`, even for a higher-priority request.
- R6: A take sets the mask (`mask_o` = 1) from the same edge that raises `take_o`.
- R7: A one-cycle `svc_ack_i` pulse clears `src_vld_o` on the next clock edge and leaves the mask set.
- R8: A `mask_clr_i` pulse clears the mask and also releases any latched winner (`src_vld_o` = 0) on the next edge. A `mask_set_i` pulse sets the mask.
- R9: A boundary that does not take raises `fetch_o` for one cycle. `take_o` and `fetch_o` are never high together.
- R10: While `rst` is high and after it: `src_vld_o` = 0, `take_o` = 0, `fetch_o` = 0, `src_idx_o` = 0, `mask_o` = 1.
- R11: A request that drops before the boundary cycle is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_SRC | Level request lines, bit 0 highest priority |
| en_i | input | NUM_SRC | Per-source enable bits |
| insn_done_i | input | 1 | Instruction-complete strobe (boundary) |
| svc_ack_i | input | 1 | Service acknowledge pulse at vector fetch |
| mask_set_i | input | 1 | Sets the global mask |
| mask_clr_i | input | 1 | Clears the global mask and releases the latch |
| take_o | output | 1 | One-cycle interrupt-take strobe |
| fetch_o | output | 1 | One-cycle fetch-next strobe for a boundary without a take |
| src_idx_o | output | IDX_W | Latched winning source index |
| src_vld_o | output | 1 | Latched index is valid |
| mask_o | output | 1 | Current global mask bit |

## Verification
Every output is registered, so each result is due one clock edge after the cycle in which its stimulus is applied. The bench drives inputs on the falling edge and waits for exactly one rising edge. It reads the outputs on the next falling edge, before it changes any input. Strobes are checked high in that single cycle and low in the cycle after. The held index and valid flag are checked again after later boundaries, acknowledges and mask clears, so that state the block must keep is checked at the ports.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    DEC_NONE  = 2'd0,
    DEC_TAKE  = 2'd1,
    DEC_FETCH = 2'd2
  } arb_dec_e;
endpackage

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] en_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               any_o
);
  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_src
      assign pend_o[g] = req_i[g] & en_i[g];
    end
  endgenerate
  assign any_o = |pend_o;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] vec_i,
  output logic [IDX_W-1:0]   idx_o
);
  // Scan from the top so the lowest set bit is the last one written.
  always_comb begin
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_latch.sv
module irq_latch
  import irq_arb_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boundary_i,
  input  logic             any_i,
  input  logic [IDX_W-1:0] win_i,
  input  logic             ack_i,
  input  logic             mset_i,
  input  logic             mclr_i,
  output logic             take_o,
  output logic             fetch_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o,
  output logic             mask_o
);
  logic             mask_q, vld_q, take_q, fetch_q;
  logic [IDX_W-1:0] idx_q;
  arb_dec_e         dec;

  always_comb begin
    dec = DEC_NONE;
    if (boundary_i) begin
      if (!mask_q && !vld_q && any_i && !ack_i) dec = DEC_TAKE;
      else                                       dec = DEC_FETCH;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= 1'b1;
      vld_q   <= 1'b0;
      idx_q   <= '0;
      take_q  <= 1'b0;
      fetch_q <= 1'b0;
    end else begin
      take_q  <= (dec == DEC_TAKE);
      fetch_q <= (dec == DEC_FETCH);
      if (dec == DEC_TAKE) begin
        vld_q  <= 1'b1;
        idx_q  <= win_i;
        mask_q <= 1'b1;
      end else begin
        if (ack_i || mclr_i) vld_q <= 1'b0;
        if (mset_i)          mask_q <= 1'b1;
        else if (mclr_i)     mask_q <= 1'b0;
      end
    end
  end

  assign take_o  = take_q;
  assign fetch_o = fetch_q;
  assign idx_o   = idx_q;
  assign vld_o   = vld_q;
  assign mask_o  = mask_q;

  // R1
  take_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    take_q |-> $past(boundary_i));
  // R2
  take_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(take_q) |-> $past(!mask_q && any_i));
  // R5
  no_preempt_chk: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !ack_i && !mclr_i) |=> (vld_q && $stable(idx_q) && !take_q));
  // R6
  take_sets_mask_chk: assert property (@(posedge clk) disable iff (rst)
    take_q |-> mask_q);
  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> !vld_q);
  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({take_q, fetch_q}));
endmodule

// File: rtl/irq_arbiter_top.sv
module irq_arbiter_top #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               insn_done_i,
  input  logic               svc_ack_i,
  input  logic               mask_set_i,
  input  logic               mask_clr_i,
  output logic               take_o,
  output logic               fetch_o,
  output logic [IDX_W-1:0]   src_idx_o,
  output logic               src_vld_o,
  output logic               mask_o
);
  logic [NUM_SRC-1:0] pend;
  logic               any_pend;
  logic [IDX_W-1:0]   win;

  irq_gate #(.NUM_SRC(NUM_SRC)) gate_i (
    .req_i (req_i),
    .en_i  (en_i),
    .pend_o(pend),
    .any_o (any_pend)
  );

  irq_prio_enc #(.NUM_SRC(NUM_SRC)) enc_i (
    .vec_i(pend),
    .idx_o(win)
  );

  irq_latch #(.IDX_W(IDX_W)) latch_i (
    .clk       (clk),
    .rst       (rst),
    .boundary_i(insn_done_i),
    .any_i     (any_pend),
    .win_i     (win),
    .ack_i     (svc_ack_i),
    .mset_i    (mask_set_i),
    .mclr_i    (mask_clr_i),
    .take_o    (take_o),
    .fetch_o   (fetch_o),
    .idx_o     (src_idx_o),
    .vld_o     (src_vld_o),
    .mask_o    (mask_o)
  );

  // R10
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!src_vld_o && !take_o && !fetch_o && mask_o));
endmodule

// File: tb/irq_arbiter_top_tb.sv
module irq_arbiter_top_tb_top;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req = '0, en = '0;
  logic done = 1'b0, ack = 1'b0, mset = 1'b0, mclr = 1'b0;
  logic take, fetch, vld, mask;
  logic [2:0] idx;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  irq_arbiter_top #(.NUM_SRC(N)) dut_i (
    .clk(clk), .rst(rst), .req_i(req), .en_i(en), .insn_done_i(done),
    .svc_ack_i(ack), .mask_set_i(mset), .mask_clr_i(mclr),
    .take_o(take), .fetch_o(fetch), .src_idx_o(idx), .src_vld_o(vld),
    .mask_o(mask)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic boundary();
    done = 1'b1; step(); done = 1'b0;
  endtask

  task automatic clr_mask();
    mclr = 1'b1; step(); mclr = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step(); rst = 1'b0;
    chk(vld == 0 && take == 0 && fetch == 0, "R10 vld/take/fetch", {vld, take, fetch}, 0);
    chk(mask == 1, "R10 mask", mask, 1);
    chk(idx == 0, "R10 idx", idx, 0);
  endtask

  task automatic t_masked();
    req = 8'h10; en = 8'hFF; boundary();
    chk(take == 0, "R2 masked take", take, 0);
    chk(fetch == 1, "R9 fetch pulse", fetch, 1);
    step();
    chk(fetch == 0, "R9 fetch one cycle", fetch, 0);
    clr_mask();
    chk(mask == 0, "R8 mask cleared", mask, 0);
  endtask

  task automatic t_no_boundary();
    req = 8'h01; en = 8'hFF;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(take == 0 && vld == 0, "R1 no take without boundary", take, 0);
    end
  endtask

  task automatic t_disabled();
    req = 8'h01; en = 8'hFE; boundary();
    chk(take == 0 && vld == 0, "R2 disabled source", take, 0);
    chk(fetch == 1, "R9 fetch on no take", fetch, 1);
  endtask

  task automatic t_priority();
    req = 8'h2C; en = 8'hFF; boundary();
    req = 8'h00;
    chk(take == 1, "R4 take strobe", take, 1);
    chk(idx == 2, "R3 lowest wins", idx, 2);
    chk(vld == 1, "R4 valid", vld, 1);
    chk(mask == 1, "R6 mask set", mask, 1);
    chk(fetch == 0, "R9 exclusive", fetch, 0);
    step();
    chk(take == 0 && vld == 1 && idx == 2, "R4 held, strobe one cycle", take, 0);
  endtask

  task automatic t_no_preempt();
    req = 8'h01; boundary();
    chk(take == 0, "R5 no preempt take", take, 0);
    chk(idx == 2 && vld == 1, "R5 index stable", idx, 2);
    mset = 1'b1; step(); mset = 1'b0;
    chk(vld == 1 && idx == 2, "R5 held across mask set", idx, 2);
  endtask

  task automatic t_ack();
    ack = 1'b1; step(); ack = 1'b0;
    chk(vld == 0, "R7 ack clears valid", vld, 0);
    chk(mask == 1, "R7 mask stays set", mask, 1);
  endtask

  task automatic t_low_then_clr();
    clr_mask();
    req = 8'h80; en = 8'hFF; boundary();
    chk(take == 1 && idx == 7, "R3 lowest priority source", idx, 7);
    clr_mask();
    chk(vld == 0, "R8 clear releases latch", vld, 0);
    chk(mask == 0, "R8 mask clear", mask, 0);
  endtask

  task automatic t_drop();
    req = 8'h40; step();
    req = 8'h00; boundary();
    chk(take == 0 && vld == 0, "R11 dropped request", take, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_masked();
    t_no_boundary();
    t_disabled();
    t_priority();
    t_no_preempt();
    t_ack();
    t_low_then_clr();
    t_drop();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule